// File: doc/BRIEF.md
# UART Receive Queue with Per-Byte Error Status

This block sits behind a UART deserializer. It collects the received frames in a first-word-fall-through queue. Each frame carries a data byte and flags for framing error, parity error and line break. Every stored byte keeps its own flags. The outputs always show the byte at the head of the queue together with the flags that belong to that byte. When the queue is full, an arriving frame is lost. This overrun is recorded on the newest stored byte, so software sees it at the exact point in the stream where the data gap lies.

The block also holds the sticky and live error and break indicators. It drives a maskable reception-error interrupt and a DMA request. The DMA request stops as soon as an error is recorded, and the offending byte stays in the queue for inspection. A flush control empties the queue. A self-clearing soft reset brings every piece of state back to its initial value, and it is the only way to clear an overrun.

Top module: `uart_rxf_top`

## Requirements
- R1: Bytes leave the queue in arrival order, and the head byte appears on `rd_data` without a read cycle. `level` counts the stored bytes (0 to 16 at the default depth of 16). `empty` is high at level 0 and `full` is high at level 16. A read of an empty queue does nothing.
- R2: `head_frm`, `head_par`, `head_brk` and `head_ovr` give the flags stored with the head byte, and they change with every read. All head outputs are 0 while the queue is empty.
- R3: A frame that arrives while the queue is full, with no read in the same cycle, is discarded. `head_ovr` of the most recently stored byte becomes 1, and `overrun` goes high and stays high.
- R4: `err_status` goes high when a frame with a framing or parity error arrives, or on an overrun. `err_clr` clears it, except that it stays high while `overrun` is high.
- R5: `err_irq` is high exactly when `err_status` is high and `err_irq_en` is 1.
- R6: `brk_sticky` goes high on a break frame and stays high until `brk_clr` is pulsed.
- R7: `brk_live` follows the break flag of the most recent accepted frame. It goes high on a break frame and drops on the next non-break frame.
- R8: `dma_req` is high when `dma_mode` is 1, the queue is not empty and `err_status` is low. After an error the request stops and the erroneous byte stays at its place in the queue.
- R9: `flush` empties the queue within one cycle and leaves `overrun` and `err_status` unchanged.
- R10: A pulse on `soft_rst_set` raises `soft_rst_busy` for exactly 4 cycles (parameter INIT_CYC). Frames, reads and controls are ignored during that time. When `soft_rst_busy` drops, the queue and all flags hold their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received frame is presented this cycle |
| in_data | input | 8 | Received data byte |
| in_frm_err | input | 1 | Frame has a framing error |
| in_par_err | input | 1 | Frame has a parity error |
| in_brk | input | 1 | Frame is a line break |
| rd_en | input | 1 | Remove the head byte |
| flush | input | 1 | Empty the queue |
| err_clr | input | 1 | Clear the error status |
| brk_clr | input | 1 | Clear the sticky break flag |
| soft_rst_set | input | 1 | Start a soft reset |
| dma_mode | input | 1 | Draining is done by DMA |
| err_irq_en | input | 1 | Reception-error interrupt enable |
| rd_data | output | 8 | Head data byte |
| head_frm | output | 1 | Framing error of the head byte |
| head_par | output | 1 | Parity error of the head byte |
| head_brk | output | 1 | Break flag of the head byte |
| head_ovr | output | 1 | Overrun followed the head byte |
| empty | output | 1 | Queue is empty |
| full | output | 1 | Queue is full |
| level | output | 5 | Number of stored bytes |
| err_status | output | 1 | Combined reception-error status |
| err_irq | output | 1 | Masked reception-error interrupt |
| overrun | output | 1 | Overrun latched since the last soft reset |
| brk_sticky | output | 1 | Break seen since the last clear |
| brk_live | output | 1 | The most recent frame was a break |
| dma_req | output | 1 | DMA read request |
| soft_rst_busy | output | 1 | Soft reset in progress |

## Verification
The hardest case to reach is the overrun mark. It needs a completely full queue, a frame arriving with no read in the same cycle, and then fifteen reads before the marked byte reaches the head. The stimulus fills the queue with sixteen numbered bytes and pushes one more. It then drains the queue and checks that only the sixteenth byte carries `head_ovr`. It also checks that neither a flush nor an error clear removes the overrun, and that only the soft reset removes it. A frame is pushed in the middle of the soft-reset window to show that it leaves no trace.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;

  typedef struct packed {
    logic       ovr;
    logic       brk;
    logic       par;
    logic       frm;
    logic [7:0] data;
  } rx_entry_t;

  function automatic logic entry_bad(input logic frm, input logic par);
    return frm | par;
  endfunction

  function automatic int unsigned ptr_fill(input int unsigned wr, input int unsigned rd,
                                           input int unsigned span);
    return (wr + span - rd) % span;
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import uart_rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       push,
  input  logic       pop,
  input  logic       mark_ovr,
  input  rx_entry_t  wr_entry,
  output rx_entry_t  head,
  output logic [AW:0] level,
  output logic       empty,
  output logic       full
);
  localparam int SPAN = 2 * DEPTH;

  rx_entry_t       mem [DEPTH];
  logic [AW:0]     wr_ptr, rd_ptr;
  logic [AW-1:0]   last_idx;

  assign last_idx = wr_ptr[AW-1:0] - 1'b1;
  assign level    = AW'(0) + (AW+1)'(ptr_fill(int'(wr_ptr), int'(rd_ptr), SPAN));
  assign empty    = (wr_ptr == rd_ptr);
  assign full     = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign head     = empty ? '0 : mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (!clr) begin
      if (push)     mem[wr_ptr[AW-1:0]] <= wr_entry;
      if (mark_ovr) mem[last_idx].ovr   <= 1'b1;
    end
  end
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic frame_evt,
  input  logic frame_brk,
  input  logic err_evt,
  input  logic ovr_evt,
  input  logic err_clr,
  input  logic brk_clr,
  output logic err_status,
  output logic overrun,
  output logic brk_sticky,
  output logic brk_live
);
  logic err_q;

  assign err_status = err_q | overrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0; overrun <= 1'b0; brk_sticky <= 1'b0; brk_live <= 1'b0;
    end else if (clr) begin
      err_q <= 1'b0; overrun <= 1'b0; brk_sticky <= 1'b0; brk_live <= 1'b0;
    end else begin
      if (ovr_evt) overrun <= 1'b1;
      if (err_evt || ovr_evt) err_q <= 1'b1;
      else if (err_clr)       err_q <= 1'b0;
      if (frame_evt && frame_brk) brk_sticky <= 1'b1;
      else if (brk_clr)           brk_sticky <= 1'b0;
      if (frame_evt) brk_live <= frame_brk;
    end
  end
endmodule

// File: rtl/rxf_softrst.sv
module rxf_softrst #(
  parameter int INIT_CYC = 4,
  localparam int CW = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (cnt == CW'(INIT_CYC - 1)) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_rxf_top.sv
module uart_rxf_top
  import uart_rxf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int INIT_CYC = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_frm_err,
  input  logic        in_par_err,
  input  logic        in_brk,
  input  logic        rd_en,
  input  logic        flush,
  input  logic        err_clr,
  input  logic        brk_clr,
  input  logic        soft_rst_set,
  input  logic        dma_mode,
  input  logic        err_irq_en,
  output logic [7:0]  rd_data,
  output logic        head_frm,
  output logic        head_par,
  output logic        head_brk,
  output logic        head_ovr,
  output logic        empty,
  output logic        full,
  output logic [AW:0] level,
  output logic        err_status,
  output logic        err_irq,
  output logic        overrun,
  output logic        brk_sticky,
  output logic        brk_live,
  output logic        dma_req,
  output logic        soft_rst_busy
);
  // Named internal events, observed by the bound checker
  logic      act, ev_frame, ev_flush, ev_pop, ev_push, ev_drop, ev_err;
  rx_entry_t in_entry, head;

  assign act      = !soft_rst_busy;
  assign ev_frame = in_valid & act;
  assign ev_flush = flush & act;
  assign ev_pop   = rd_en & !empty & act & !ev_flush;
  assign ev_push  = ev_frame & !ev_flush & (!full | ev_pop);
  assign ev_drop  = ev_frame & !ev_flush & full & !ev_pop;
  assign ev_err   = ev_frame & entry_bad(in_frm_err, in_par_err);

  assign in_entry = '{ovr: 1'b0, brk: in_brk, par: in_par_err, frm: in_frm_err, data: in_data};

  rxf_softrst #(.INIT_CYC(INIT_CYC)) u_srst (
    .clk(clk), .rst_n(rst_n), .start(soft_rst_set), .busy(soft_rst_busy)
  );

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst_busy | ev_flush),
    .push(ev_push), .pop(ev_pop), .mark_ovr(ev_drop), .wr_entry(in_entry),
    .head(head), .level(level), .empty(empty), .full(full)
  );

  rxf_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst_busy),
    .frame_evt(ev_frame), .frame_brk(in_brk), .err_evt(ev_err), .ovr_evt(ev_drop),
    .err_clr(err_clr & act), .brk_clr(brk_clr & act),
    .err_status(err_status), .overrun(overrun),
    .brk_sticky(brk_sticky), .brk_live(brk_live)
  );

  assign rd_data  = head.data;
  assign head_frm = head.frm;
  assign head_par = head.par;
  assign head_brk = head.brk;
  assign head_ovr = head.ovr;
  assign err_irq  = err_status & err_irq_en;
  assign dma_req  = dma_mode & !empty & !err_status & act;
endmodule

// File: rtl/uart_rxf_chk.sv
module uart_rxf_chk #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        ev_drop,
  input logic        ev_push,
  input logic        ev_flush,
  input logic        ev_frame,
  input logic        in_brk,
  input logic        brk_clr,
  input logic        full,
  input logic        empty,
  input logic [AW:0] level,
  input logic        err_status,
  input logic        err_irq,
  input logic        overrun,
  input logic        brk_sticky,
  input logic        brk_live,
  input logic        dma_req
);
  p_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));
  p_drop_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> overrun && full);
  p_drop_no_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |-> !ev_push);
  p_ovr_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !busy |=> overrun);
  p_ovr_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> err_status);
  p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> err_status);
  p_brk_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_sticky && !brk_clr && !busy |=> brk_sticky);
  p_brk_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame && in_brk |=> brk_live && brk_sticky);
  p_dma_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_status |-> !dma_req);
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flush |=> empty);
  p_busy_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> empty && !overrun);
endmodule

bind uart_rxf_top uart_rxf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(soft_rst_busy), .ev_drop(ev_drop), .ev_push(ev_push),
  .ev_flush(ev_flush), .ev_frame(ev_frame), .in_brk(in_brk), .brk_clr(brk_clr),
  .full(full), .empty(empty), .level(level), .err_status(err_status), .err_irq(err_irq),
  .overrun(overrun), .brk_sticky(brk_sticky), .brk_live(brk_live), .dma_req(dma_req)
);

// File: tb/uart_rxf_top_tb.sv
module uart_rxf_top_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_frm_err = 0, in_par_err = 0, in_brk = 0;
  logic [7:0] in_data = '0;
  logic rd_en = 0, flush = 0, err_clr = 0, brk_clr = 0, soft_rst_set = 0;
  logic dma_mode = 0, err_irq_en = 0;
  logic [7:0] rd_data;
  logic head_frm, head_par, head_brk, head_ovr, empty, full;
  logic [4:0] level;
  logic err_status, err_irq, overrun, brk_sticky, brk_live, dma_req, soft_rst_busy;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_rxf_top u_dut (.*);

  // {brk, par, frm, data}
  localparam logic [10:0] VEC [8] = '{
    {3'b000, 8'h11}, {3'b010, 8'h22}, {3'b001, 8'h33}, {3'b101, 8'h00},
    {3'b000, 8'h44}, {3'b011, 8'h55}, {3'b000, 8'h66}, {3'b000, 8'h77}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [7:0] d, input logic f, input logic p, input logic b);
    in_valid = 1; in_data = d; in_frm_err = f; in_par_err = p; in_brk = b;
    tick();
    in_valid = 0; in_frm_err = 0; in_par_err = 0; in_brk = 0;
  endtask

  task automatic pop();
    rd_en = 1; tick(); rd_en = 0;
  endtask

  task automatic pulse_clr(input bit which);
    if (which) brk_clr = 1; else err_clr = 1;
    tick();
    brk_clr = 0; err_clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // reset state
    check("R1 reset empty", empty, 1);
    check("R1 reset level", level, 0);
    check("R4 reset err", err_status, 0);
    check("R6 reset brk", brk_sticky, 0);
    check("R2 empty head", {head_ovr, head_brk, head_par, head_frm, rd_data}, 0);

    // table-driven stream
    for (int i = 0; i < 8; i++) begin
      push(VEC[i][7:0], VEC[i][8], VEC[i][9], VEC[i][10]);
      check("R7 live break", brk_live, VEC[i][10]);
      check("R1 level", level, i + 1);
    end
    check("R4 err after bad frames", err_status, 1);
    check("R6 sticky break", brk_sticky, 1);
    check("R5 irq masked", err_irq, 0);
    err_irq_en = 1; #1;
    check("R5 irq enabled", err_irq, 1);
    for (int i = 0; i < 8; i++) begin
      check("R1 order", rd_data, VEC[i][7:0]);
      check("R2 head flags", {head_ovr, head_brk, head_par, head_frm},
            {1'b0, VEC[i][10], VEC[i][9], VEC[i][8]});
      pop();
    end
    check("R1 drained", empty, 1);
    pop();
    check("R1 read empty ignored", level, 0);
    pulse_clr(0);
    check("R4 err clear", err_status, 0);
    check("R5 irq follows", err_irq, 0);
    check("R6 sticky kept without clear", brk_sticky, 1);
    pulse_clr(1);
    check("R6 sticky clear", brk_sticky, 0);

    // DMA stop on error
    dma_mode = 1; #1;
    check("R8 no req when empty", dma_req, 0);
    push(8'h5A, 0, 0, 0);
    check("R8 req good byte", dma_req, 1);
    pop();
    push(8'hA5, 0, 1, 0);
    check("R8 req stops", dma_req, 0);
    check("R8 byte kept", rd_data, 8'hA5);
    check("R8 flag kept", head_par, 1);
    pulse_clr(0);
    check("R8 req resumes", dma_req, 1);
    pop();
    dma_mode = 0;

    // flush
    push(8'h01, 0, 0, 0); push(8'h02, 0, 0, 0); push(8'h03, 0, 0, 0);
    flush = 1; tick(); flush = 0;
    check("R9 flush empties", level, 0);

    // overrun
    for (int i = 0; i < 16; i++) push(8'(i), 0, 0, 0);
    check("R1 full", full, 1);
    check("R3 no overrun yet", overrun, 0);
    push(8'hAA, 0, 0, 0);
    check("R3 overrun set", overrun, 1);
    check("R3 level kept", level, 16);
    check("R4 err on overrun", err_status, 1);
    pulse_clr(0);
    check("R4 overrun keeps err", err_status, 1);
    for (int i = 0; i < 16; i++) begin
      check("R3 data", rd_data, i);
      check("R3 mark position", head_ovr, (i == 15) ? 1 : 0);
      pop();
    end
    push(8'h09, 0, 0, 0);
    flush = 1; tick(); flush = 0;
    check("R9 flush empties", empty, 1);
    check("R9 overrun survives flush", overrun, 1);
    check("R9 err survives flush", err_status, 1);

    // soft reset
    push(8'h0F, 0, 0, 1);
    soft_rst_set = 1; tick(); soft_rst_set = 0;
    begin
      int n = 0;
      while (soft_rst_busy && n < 20) begin
        n++;
        if (n == 2) begin
          in_valid = 1; in_data = 8'hEE; in_brk = 1; in_par_err = 1;
        end
        tick();
        in_valid = 0; in_brk = 0; in_par_err = 0;
      end
      check("R10 busy length", n, 4);
    end
    check("R10 overrun cleared", overrun, 0);
    check("R10 err cleared", err_status, 0);
    check("R10 queue empty", empty, 1);
    check("R10 break ignored", {brk_sticky, brk_live}, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule